// File: doc/BRIEF.md
# Quarter-Rate Polyphase Digital Downconverter

This block takes a real, signed intermediate-frequency sample stream whose band is centred at one quarter of the sample rate. It turns that stream into complex baseband and decimates it by four. No oscillator is needed. At fs/4 the cosine and sine mixing sequences only take the values 0, +1 and -1. Mixing therefore reduces to routing: even-indexed samples feed the in-phase branch, odd-indexed samples feed the quadrature branch, and every second sample on each branch has its sign inverted.

A 31-tap real lowpass filter with symmetric coefficients follows the mixer. Half the mixed samples are zero, so the filter splits into two polyphase branches. The in-phase branch uses the odd taps and the quadrature branch uses the even taps. The two samples that share a coefficient are added before the multiply. Each output pair then needs 16 multiplies, and one multiplier performs all of them over the 16 clocks between outputs. The processing clock runs at four times the input sample rate. The sixteen unique coefficients are a parameter fixed at elaboration time.

Top module: `qrate_ddc`

## Requirements
- R1: A synchronous active-high reset clears the phase counter, fill counter, delay lines, pipeline and accumulators. While reset is held, and in the first cycle after it, `out_valid` is 0 and both outputs are 0.
- R2: Accepted inputs are numbered n = 0, 1, 2, … from the first one after reset. The in-phase branch receives +x for n mod 4 = 0, -x for n mod 4 = 2, and 0 otherwise. The quadrature branch receives +x for n mod 4 = 1, -x for n mod 4 = 3, and 0 otherwise. Negating -32768 gives +32768 without wrapping.
- R3: For an output at input index n, each branch produces the sum over k = 0..30 of h[k]·m[n−k], where h[k] = h[30−k]. The value h[j] for j = 0..15 is the signed slice `COEFS[16*j +: 16]`, and h[15] is the centre tap.
- R4: One output pair is produced for each group of four accepted inputs. It belongs to the input with n mod 4 = 3.
- R5: No output is produced before input n = 31 has been accepted. The output belonging to n = 31 is the first.
- R6: Each branch sum is scaled by 2^-FRAC_BITS (default 15) with round-half-up: floor((sum + 2^(FRAC_BITS−1)) / 2^FRAC_BITS).
- R7: Each scaled result saturates to the signed 16-bit range [−32768, 32767].
- R8: `out_valid` is a single-cycle pulse. `out_i` and `out_q` change only in a cycle where `out_valid` is 1, and they hold their values otherwise.
- R9: `in_sample` is ignored in every cycle where `in_valid` is 0.
- R10: Inputs may arrive as often as every fourth clock, which is the full rate, with no loss or corruption. Any longer, irregular spacing is also accepted.
- R11: An output pulse appears exactly 20 cycles (2·L+4, with L = (NUM_TAPS+1)/4) after the clock edge that accepted its n mod 4 = 3 input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock, four times the input sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a valid input sample |
| in_sample | input | 16 | Signed real IF sample |
| out_valid | output | 1 | One-cycle strobe marking a new output pair |
| out_i | output | 16 | Signed in-phase baseband sample |
| out_q | output | 16 | Signed quadrature baseband sample |

## Verification
The bench builds the block with its own coefficients: 1500 + 150·j for j = 0..14, a centre tap of 2048, and FRAC_BITS of 15. With this set, each branch's DC gain exceeds one, so a full-scale constant baseband input reaches saturation in both directions. The centre tap of 2048 also gives an exact half-LSB (8 × 2048 = 2^14) when an impulse of amplitude ±8 passes through the centre, which tests the direction of round-half-up. The bench drives random streams at full rate and with irregular gaps. It applies a mid-stream reset to re-test the fill rule, and it checks the arrival cycle of every output.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    // Commutation phase of the current input sample (order is behaviour)
    typedef enum logic [1:0] {
        PH_I_POS = 2'd0,
        PH_Q_POS = 2'd1,
        PH_I_NEG = 2'd2,
        PH_Q_NEG = 2'd3
    } mix_phase_e;

    localparam int IDX_W = 5;

    // One entry of the multiply schedule
    typedef struct packed {
        logic             is_q;
        logic             pair;
        logic [IDX_W-1:0] a;
        logic [IDX_W-1:0] b;
        logic [IDX_W-1:0] coef;
    } tap_plan_t;

    function automatic mix_phase_e next_phase(input mix_phase_e p);
        case (p)
            PH_I_POS: return PH_Q_POS;
            PH_Q_POS: return PH_I_NEG;
            PH_I_NEG: return PH_Q_NEG;
            default:  return PH_I_POS;
        endcase
    endfunction

    // Steps 0..L-1 serve the in-phase branch (odd taps, centre last),
    // steps L..2L-1 serve the quadrature branch (even taps, all paired).
    function automatic tap_plan_t plan_step(input int step, input int half_len);
        tap_plan_t p;
        int i;
        if (step < half_len) begin
            i      = step;
            p.is_q = 1'b0;
            if (i < half_len - 1) begin
                p.pair = 1'b1;
                p.a    = IDX_W'(i);
                p.b    = IDX_W'(2*half_len - 2 - i);
                p.coef = IDX_W'(2*i + 1);
            end else begin
                p.pair = 1'b0;
                p.a    = IDX_W'(half_len - 1);
                p.b    = IDX_W'(half_len - 1);
                p.coef = IDX_W'(2*half_len - 1);
            end
        end else begin
            i      = step - half_len;
            p.is_q = 1'b1;
            p.pair = 1'b1;
            p.a    = IDX_W'(i);
            p.b    = IDX_W'(2*half_len - 1 - i);
            p.coef = IDX_W'(2*i);
        end
        return p;
    endfunction

endpackage

// File: rtl/ddc_commutator.sv
module ddc_commutator
    import ddc_pkg::*;
#(
    parameter int SMP_W    = 16,
    parameter int NUM_TAPS = 31
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_sample,
    output logic                    push_i,
    output logic                    push_q,
    output logic signed [SMP_W:0]   mixed,
    output logic                    frame_done
);
    localparam int CNT_W = $clog2(NUM_TAPS + 1);

    mix_phase_e       phase;
    logic [CNT_W-1:0] seen;
    logic             negate;
    logic signed [SMP_W:0] ext;

    always_comb begin
        negate = (phase == PH_I_NEG) || (phase == PH_Q_NEG);
        push_i = in_valid && ((phase == PH_I_POS) || (phase == PH_I_NEG));
        push_q = in_valid && ((phase == PH_Q_POS) || (phase == PH_Q_NEG));
        ext    = (SMP_W+1)'(in_sample);
        mixed  = negate ? -ext : ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_I_POS;
            seen       <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (in_valid) begin
                phase <= next_phase(phase);
                if (seen != CNT_W'(NUM_TAPS))
                    seen <= seen + 1'b1;
                frame_done <= (phase == PH_Q_NEG) && (seen == CNT_W'(NUM_TAPS));
            end
        end
    end

endmodule

// File: rtl/ddc_branch_store.sv
module ddc_branch_store #(
    parameter int MIX_W    = 17,
    parameter int HALF_LEN = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push_i,
    input  logic                    push_q,
    input  logic signed [MIX_W-1:0] din,
    input  logic                    load,
    output logic signed [MIX_W-1:0] snap_i [0:2*HALF_LEN-2],
    output logic signed [MIX_W-1:0] snap_q [0:2*HALF_LEN-1]
);
    localparam int I_DEP = 2*HALF_LEN - 1;
    localparam int Q_DEP = 2*HALF_LEN;

    logic signed [MIX_W-1:0] line_i [0:I_DEP-1];
    logic signed [MIX_W-1:0] line_q [0:Q_DEP-1];

    for (genvar g = 0; g < I_DEP; g++) begin : g_istage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    line_i[g] <= '0;
                    snap_i[g] <= '0;
                end else begin
                    if (push_i) line_i[g] <= din;
                    if (load)   snap_i[g] <= line_i[g];
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    line_i[g] <= '0;
                    snap_i[g] <= '0;
                end else begin
                    if (push_i) line_i[g] <= line_i[g-1];
                    if (load)   snap_i[g] <= line_i[g];
                end
            end
        end
    end

    for (genvar g = 0; g < Q_DEP; g++) begin : g_qstage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    line_q[g] <= '0;
                    snap_q[g] <= '0;
                end else begin
                    if (push_q) line_q[g] <= din;
                    if (load)   snap_q[g] <= line_q[g];
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    line_q[g] <= '0;
                    snap_q[g] <= '0;
                end else begin
                    if (push_q) line_q[g] <= line_q[g-1];
                    if (load)   snap_q[g] <= line_q[g];
                end
            end
        end
    end

endmodule

// File: rtl/ddc_mac_engine.sv
module ddc_mac_engine
    import ddc_pkg::*;
#(
    parameter int MIX_W     = 17,
    parameter int COEF_W    = 16,
    parameter int HALF_LEN  = 8,
    parameter int FRAC_BITS = 15,
    parameter int OUT_W     = 16,
    parameter logic [COEF_W*2*HALF_LEN-1:0] COEFS = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [MIX_W-1:0] snap_i [0:2*HALF_LEN-2],
    input  logic signed [MIX_W-1:0] snap_q [0:2*HALF_LEN-1],
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);
    localparam int N_STEPS = 2*HALF_LEN;
    localparam int STEP_W  = $clog2(N_STEPS);
    localparam int I_IW    = $clog2(2*HALF_LEN - 1);
    localparam int Q_IW    = $clog2(2*HALF_LEN);
    localparam int C_IW    = $clog2(2*HALF_LEN);
    localparam int PRE_W   = MIX_W + 1;
    localparam int PROD_W  = PRE_W + COEF_W;
    localparam int ACC_W   = PROD_W + $clog2(N_STEPS) + 1;

    localparam logic signed [ACC_W-1:0] MAXV =
        {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = ~MAXV;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) << (FRAC_BITS-1);

    logic signed [COEF_W-1:0] coef_tab [0:2*HALF_LEN-1];
    for (genvar g = 0; g < 2*HALF_LEN; g++) begin : g_coef
        assign coef_tab[g] = COEFS[g*COEF_W +: COEF_W];
    end

    logic                     active;
    logic [STEP_W-1:0]        step;
    tap_plan_t                plan;
    logic signed [MIX_W-1:0]  opa, opb;
    logic signed [PRE_W-1:0]  pre;
    logic signed [PROD_W-1:0] prod_c, prod_q;
    logic                     prod_vld;
    logic [STEP_W-1:0]        prod_step;
    logic signed [ACC_W-1:0]  acc_i, acc_q;
    logic                     fin;

    // Sequencer: one schedule step per clock
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            step   <= '0;
        end else if (start) begin
            active <= 1'b1;
            step   <= '0;
        end else if (active) begin
            if (step == STEP_W'(N_STEPS-1)) active <= 1'b0;
            else                            step   <= step + 1'b1;
        end
    end

    // Operand select, pre-add and the single shared multiply
    always_comb begin
        plan = plan_step(int'(step), HALF_LEN);
        if (plan.is_q) begin
            opa = snap_q[Q_IW'(plan.a)];
            opb = snap_q[Q_IW'(plan.b)];
        end else begin
            opa = snap_i[I_IW'(plan.a)];
            opb = snap_i[I_IW'(plan.b)];
        end
        if (!plan.pair) opb = '0;
        pre    = PRE_W'(opa) + PRE_W'(opb);
        prod_c = PROD_W'(pre) * PROD_W'(coef_tab[C_IW'(plan.coef)]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q    <= '0;
            prod_vld  <= 1'b0;
            prod_step <= '0;
        end else begin
            prod_q    <= prod_c;
            prod_vld  <= active;
            prod_step <= step;
        end
    end

    // Two branch accumulators
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_i <= '0;
            acc_q <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= prod_vld && (prod_step == STEP_W'(N_STEPS-1));
            if (prod_vld) begin
                if (prod_step == '0)
                    acc_i <= ACC_W'(prod_q);
                else if (prod_step < STEP_W'(HALF_LEN))
                    acc_i <= acc_i + ACC_W'(prod_q);
                else if (prod_step == STEP_W'(HALF_LEN))
                    acc_q <= ACC_W'(prod_q);
                else
                    acc_q <= acc_q + ACC_W'(prod_q);
            end
        end
    end

    function automatic logic signed [OUT_W-1:0] scale(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] r;
        r = (a + RND) >>> FRAC_BITS;
        if (r > MAXV)      return MAXV[OUT_W-1:0];
        else if (r < MINV) return MINV[OUT_W-1:0];
        else               return r[OUT_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= fin;
            if (fin) begin
                out_i <= scale(acc_i);
                out_q <= scale(acc_q);
            end
        end
    end

endmodule

// File: rtl/qrate_ddc.sv
module qrate_ddc #(
    parameter int SMP_W     = 16,
    parameter int COEF_W    = 16,
    parameter int NUM_TAPS  = 31,
    parameter int FRAC_BITS = 15,
    parameter logic [COEF_W*(NUM_TAPS+1)/2-1:0] COEFS = {
        16'sd9216, 16'sd8704, 16'sd7424, 16'sd5632,
        16'sd3584, 16'sd1664, 16'sd256,  -16'sd640,
        -16'sd960, -16'sd832, -16'sd448, -16'sd64,
        16'sd160,  16'sd192,  16'sd96,   16'sd16
    }
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_sample,
    output logic                    out_valid,
    output logic signed [SMP_W-1:0] out_i,
    output logic signed [SMP_W-1:0] out_q
);
    // NUM_TAPS must be 4*L-1 with L <= 8 (2L multiplies fit in 16 clocks)
    localparam int HALF_LEN = (NUM_TAPS + 1) / 4;
    localparam int MIX_W    = SMP_W + 1;

    logic                    push_i, push_q, frame_done;
    logic signed [MIX_W-1:0] mixed;
    logic signed [MIX_W-1:0] snap_i [0:2*HALF_LEN-2];
    logic signed [MIX_W-1:0] snap_q [0:2*HALF_LEN-1];

    ddc_commutator #(
        .SMP_W   (SMP_W),
        .NUM_TAPS(NUM_TAPS)
    ) u_mix (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .push_i    (push_i),
        .push_q    (push_q),
        .mixed     (mixed),
        .frame_done(frame_done)
    );

    ddc_branch_store #(
        .MIX_W   (MIX_W),
        .HALF_LEN(HALF_LEN)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .push_i(push_i),
        .push_q(push_q),
        .din   (mixed),
        .load  (frame_done),
        .snap_i(snap_i),
        .snap_q(snap_q)
    );

    ddc_mac_engine #(
        .MIX_W    (MIX_W),
        .COEF_W   (COEF_W),
        .HALF_LEN (HALF_LEN),
        .FRAC_BITS(FRAC_BITS),
        .OUT_W    (SMP_W),
        .COEFS    (COEFS)
    ) u_mac (
        .clk      (clk),
        .rst      (rst),
        .start    (frame_done),
        .snap_i   (snap_i),
        .snap_q   (snap_q),
        .out_valid(out_valid),
        .out_i    (out_i),
        .out_q    (out_q)
    );

endmodule

// File: rtl/ddc_checks.sv
module ddc_checks #(
    parameter int NUM_TAPS = 31,
    parameter int OUT_W    = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q
);
    localparam int LAT   = 2*((NUM_TAPS + 1) / 4) + 4;
    localparam int CNT_W = $clog2(NUM_TAPS + 2);

    logic [1:0]       ph;
    logic [CNT_W-1:0] cnt;
    logic             frame_evt;
    logic [LAT-1:0]   fpipe;

    assign frame_evt = in_valid && (ph == 2'd3) && (cnt >= CNT_W'(NUM_TAPS));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= '0;
            cnt   <= '0;
            fpipe <= '0;
        end else begin
            fpipe <= {fpipe[LAT-2:0], frame_evt};
            if (in_valid) begin
                ph <= ph + 2'd1;
                if (cnt != CNT_W'(NUM_TAPS + 1)) cnt <= cnt + 1'b1;
            end
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_i == '0 && out_q == '0));

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));

    // R10
    spacing_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (!$past(in_valid, 1) && !$past(in_valid, 2) && !$past(in_valid, 3)));

    // R5
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cnt > CNT_W'(NUM_TAPS)));

    // R11
    lat_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        fpipe[LAT-1] |-> out_valid);

    // R4
    lat_back_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> fpipe[LAT-1]);

endmodule

bind qrate_ddc ddc_checks #(
    .NUM_TAPS(NUM_TAPS),
    .OUT_W   (SMP_W)
) u_checks (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_i    (out_i),
    .out_q    (out_q)
);

// File: tb/sim_qrate_ddc.sv
`timescale 1ns/1ps
module sim_qrate_ddc;

    function automatic logic [255:0] tb_coefs();
        logic [255:0] v;
        for (int j = 0; j < 16; j++)
            v[j*16 +: 16] = (j == 15) ? 16'd2048 : 16'(1500 + 150*j);
        return v;
    endfunction

    localparam logic [255:0] TB_COEFS = tb_coefs();
    localparam int LATENCY = 20;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    always #5 clk = ~clk;

    qrate_ddc #(
        .SMP_W(16), .COEF_W(16), .NUM_TAPS(31), .FRAC_BITS(15), .COEFS(TB_COEFS)
    ) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    typedef struct {
        int     ei;
        int     eq;
        longint ecyc;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    int     outs_seen = 0;
    bit     done = 1'b0;

    int mi [0:4095];
    int mq [0:4095];
    int n_idx = 0;
    string cur_tag = "R3";

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int hk(input int k);
        int j;
        j = (k < 15) ? k : 30 - k;
        return (j == 15) ? 2048 : 1500 + 150*j;
    endfunction

    function automatic int model(input int n, input bit q);
        longint acc = 0;
        longint r;
        for (int k = 0; k <= 30; k++)
            acc += longint'(hk(k)) * longint'(q ? mq[n-k] : mi[n-k]);
        r = (acc + 16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // Driver: presents one sample, updates the model, queues the expectation
    task automatic send(input int x, input int gap);
        exp_t e;
        longint dc;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 16'(x);
        dc = cyc;
        case (n_idx % 4)
            0: begin mi[n_idx] = x;  mq[n_idx] = 0;  end
            1: begin mi[n_idx] = 0;  mq[n_idx] = x;  end
            2: begin mi[n_idx] = -x; mq[n_idx] = 0;  end
            default: begin mi[n_idx] = 0; mq[n_idx] = -x; end
        endcase
        if ((n_idx % 4 == 3) && (n_idx >= 31)) begin
            e.ei = model(n_idx, 1'b0);
            e.eq = model(n_idx, 1'b1);
            e.ecyc = dc + LATENCY;
            e.tag = cur_tag;
            sb.push_back(e);
        end
        n_idx++;
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = 16'($urandom);   // R9: junk while not valid
        repeat (gap - 2) @(negedge clk);
    endtask

    // Monitor: pops and compares as results appear
    bit prev_v = 1'b0;
    logic signed [15:0] last_i = '0, last_q = '0;
    always @(negedge clk) begin
        if (rst) begin
            prev_v = 1'b0;
        end else begin
            if (prev_v) begin
                check(!out_valid, "R8", "valid pulse width", longint'(out_valid), 0);
                check(out_i == last_i && out_q == last_q, "R8", "hold after pulse",
                      longint'(out_i), longint'(last_i));
            end
            if (out_valid) begin
                outs_seen++;
                if (sb.size() == 0) begin
                    check(1'b0, "R5", "unexpected output", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(out_i) == e.ei, e.tag, "out_i", longint'(out_i), longint'(e.ei));
                    check(int'(out_q) == e.eq, e.tag, "out_q", longint'(out_q), longint'(e.eq));
                    check(cyc == e.ecyc, "R11", "output cycle", cyc, e.ecyc);
                end
                last_i = out_i;
                last_q = out_q;
            end
            prev_v = out_valid;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check(!out_valid && out_i == 0 && out_q == 0, "R1", "outputs in reset",
              longint'(out_i), 0);
        rst = 1'b0;
        n_idx = 0;
        @(negedge clk);
        check(!out_valid && out_i == 0 && out_q == 0, "R1", "outputs after reset",
              longint'(out_valid), 0);
    endtask

    task automatic drain(input string tag);
        repeat (LATENCY + 8) @(negedge clk);
        check(sb.size() == 0, tag, "pending outputs", sb.size(), 0);
    endtask

    task automatic align4();
        while (n_idx % 4 != 0) send(0, 4);
    endtask

    initial begin
        int base;
        do_reset();

        // Full-rate random stream
        cur_tag = "R2,R3,R4,R10";
        for (int i = 0; i < 160; i++) send(int'($signed(16'($urandom))), 4);
        drain("R4");

        // Irregular spacing with junk between strobes
        cur_tag = "R9";
        for (int i = 0; i < 80; i++) send(int'($signed(16'($urandom))), 4 + ($urandom % 6));
        drain("R9");

        // Exact half-LSB through the centre tap
        cur_tag = "R6";
        for (int i = 0; i < 36; i++) send(0, 4);
        align4();
        send(8, 4);
        for (int i = 0; i < 35; i++) send(0, 4);
        align4();
        send(-8, 4);
        for (int i = 0; i < 35; i++) send(0, 4);
        drain("R6");

        // Saturation both ways
        cur_tag = "R7";
        align4();
        for (int i = 0; i < 12; i++) begin
            send(32767, 4); send(32767, 4); send(-32767, 4); send(-32767, 4);
        end
        for (int i = 0; i < 12; i++) begin
            send(-32768, 4); send(-32768, 4); send(32767, 4); send(32767, 4);
        end
        drain("R7");

        // Reset mid-stream, then the fill rule again
        cur_tag = "R5";
        do_reset();
        base = outs_seen;
        for (int i = 0; i < 31; i++) send(int'($signed(16'($urandom))), 4);
        repeat (LATENCY + 10) @(negedge clk);
        check(outs_seen == base, "R5", "outputs before fill", outs_seen - base, 0);
        send(int'($signed(16'($urandom))), 4);
        repeat (LATENCY + 4) @(negedge clk);
        check(outs_seen == base + 1, "R5", "first output after fill", outs_seen - base, 1);
        drain("R5");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule